// File: doc/BRIEF.md
# I2S stereo serial transmitter

This block takes 32-bit stereo words from a valid/ready source and sends them as a three-wire serial stream: a bit clock, a word clock and a data line. Each word holds two 16-bit samples. The upper half goes out while the word clock is high (the right channel) and the lower half while it is low (the left channel). Within each half the most significant bit goes first. The single-cycle `tick_en` input sets the base rate, and every bit slot takes six ticks. A frame is 32 slots.

At the end of each frame the block takes a new word if one is offered. If none is offered, it sends the held word again, and the clocks keep running without a gap. Two inputs change only at frame boundaries. One selects standard I2S or left-justified word-clock timing. The other chooses which of two output pins carries the bit clock and which carries the word clock.

Top module: `i2s_stereo_tx`

## Requirements
- R1: After reset, and before any tick, tx_pin_a = 1, tx_pin_b = 1, tx_sd = 0 and in_ready = 0. The bit clock and the word clock are both high and the held word is zero.
- R2: Each bit slot lasts 6 ticks: 3 ticks with the bit clock low, then 3 ticks with it high. A frame is 32 slots (192 ticks). The bit clock stays high through the last slot's high phase, where the fetch happens.
- R3: In slot k (0..31) of a frame, tx_sd carries bit 31-k of the held word. Bits 31..16 are therefore sent first, most significant bit first.
- R4: In standard mode (lj_mode = 0) the word clock is high in slots 0..14 and in slot 31, and low in slots 15..30.
- R5: In left-justified mode (lj_mode = 1) the word clock is high in slots 0..15 and low in slots 16..31.
- R6: With clk_swap = 0, tx_pin_a carries the bit clock and tx_pin_b the word clock. With clk_swap = 1 the two are exchanged, and each waveform is otherwise unchanged.
- R7: in_ready is high only in the cycle of the last tick of a frame (slot 31, sixth tick, with tick_en high), for exactly one cycle. A word offered with in_valid in that cycle is the one sent in the next frame.
- R8: If in_valid is low in the fetch cycle, the next frame sends the held word again. Right after reset that word is zero.
- R9: lj_mode and clk_swap are sampled only in the fetch cycle. A change during a frame does not affect that frame.
- R10: While tick_en is low, all outputs hold their values and in_ready stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Base tick enable, one cycle per tick |
| lj_mode | input | 1 | 0 = standard I2S word clock, 1 = left-justified |
| clk_swap | input | 1 | 1 = exchange the bit clock and word clock pins |
| in_valid | input | 1 | A stereo word is offered |
| in_data | input | 32 | Stereo word: [31:16] first channel, [15:0] second channel |
| in_ready | output | 1 | Fetch cycle; the offered word is accepted |
| tx_pin_a | output | 1 | Bit clock (or word clock when swapped) |
| tx_pin_b | output | 1 | Word clock (or bit clock when swapped) |
| tx_sd | output | 1 | Serial data |

## Verification
A slot or tick counter that is off by one shows within one slot. The bit clock edges slide against the expected six-tick grid, and in_ready moves away from the 192nd tick. A wrong held word or a wrong bit index appears on tx_sd in the first slot whose bit differs. A mode or swap register that loads at the wrong time changes the word clock or the pin mapping before the frame boundary. Every one of these shows up in the frame where the fault occurs, because the bench compares all three pins on every cycle of that frame.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  typedef enum logic {
    FRAME_STD = 1'b0,
    FRAME_LJ  = 1'b1
  } frame_mode_e;
endpackage

// File: rtl/i2s_tx_timing.sv
// Slot and tick-phase counters; marks the fetch tick at the end of a frame.
module i2s_tx_timing #(
  parameter int HALF_BITS  = 16,
  parameter int HALF_TICKS = 3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  tick_en,
  output logic [$clog2(2*HALF_BITS)-1:0]        slot_idx,
  output logic                                  bit_clk,
  output logic                                  frame_end
);
  localparam int SLOT_W = $clog2(2*HALF_BITS);
  localparam int PH_W   = $clog2(2*HALF_TICKS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(2*HALF_BITS - 1);
  localparam logic [PH_W-1:0]   LAST_PH   = PH_W'(2*HALF_TICKS - 1);
  localparam logic [PH_W-1:0]   PH_HIGH   = PH_W'(HALF_TICKS);

  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [PH_W-1:0]   ph_q, ph_d;

  always_comb begin
    slot_d = slot_q;
    ph_d   = ph_q;
    if (tick_en) begin
      if (ph_q == LAST_PH) begin
        ph_d   = '0;
        slot_d = (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
      end else begin
        ph_d = ph_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= LAST_SLOT;
      ph_q   <= PH_HIGH;
    end else begin
      slot_q <= slot_d;
      ph_q   <= ph_d;
    end
  end

  assign slot_idx  = slot_q;
  assign bit_clk   = (ph_q >= PH_HIGH);
  assign frame_end = tick_en && (slot_q == LAST_SLOT) && (ph_q == LAST_PH);
endmodule

// File: rtl/i2s_tx_frame_store.sv
// Held stereo word plus the per-frame mode and swap latches.
module i2s_tx_frame_store
  import i2s_tx_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  logic              lj_in,
  input  logic              swap_in,
  output logic [WORD_W-1:0] held_word,
  output frame_mode_e       mode_q,
  output logic              swap_q
);
  logic [WORD_W-1:0] word_q, word_d;
  frame_mode_e       mode_r, mode_d;
  logic              swap_r, swap_d;

  always_comb begin
    word_d = word_q;
    mode_d = mode_r;
    swap_d = swap_r;
    if (load) begin
      if (in_valid) word_d = in_data;
      mode_d = frame_mode_e'(lj_in);
      swap_d = swap_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      mode_r <= FRAME_STD;
      swap_r <= 1'b0;
    end else begin
      word_q <= word_d;
      mode_r <= mode_d;
      swap_r <= swap_d;
    end
  end

  assign held_word = word_q;
  assign mode_q    = mode_r;
  assign swap_q    = swap_r;
endmodule

// File: rtl/i2s_tx_pins.sv
// Word-clock decode, data bit select and pin mapping.
module i2s_tx_pins
  import i2s_tx_pkg::*;
#(
  parameter int HALF_BITS = 16
) (
  input  logic [$clog2(2*HALF_BITS)-1:0] slot_idx,
  input  logic                           bit_clk,
  input  logic [2*HALF_BITS-1:0]         held_word,
  input  frame_mode_e                    mode,
  input  logic                           swap,
  output logic                           word_clk,
  output logic                           pin_a,
  output logic                           pin_b,
  output logic                           sd
);
  localparam int SLOT_W = $clog2(2*HALF_BITS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(2*HALF_BITS - 1);
  localparam logic [SLOT_W-1:0] HALF_CNT  = SLOT_W'(HALF_BITS);
  localparam logic [SLOT_W-1:0] HALF_PRE  = SLOT_W'(HALF_BITS - 1);

  always_comb begin
    if (mode == FRAME_LJ) word_clk = (slot_idx < HALF_CNT);
    else                  word_clk = (slot_idx < HALF_PRE) || (slot_idx == LAST_SLOT);
  end

  assign sd    = held_word[LAST_SLOT - slot_idx];
  assign pin_a = swap ? word_clk : bit_clk;
  assign pin_b = swap ? bit_clk  : word_clk;
endmodule

// File: rtl/i2s_stereo_tx.sv
module i2s_stereo_tx
  import i2s_tx_pkg::*;
#(
  parameter int HALF_BITS  = 16,
  parameter int HALF_TICKS = 3,
  localparam int WORD_W    = 2*HALF_BITS,
  localparam int SLOT_W    = $clog2(2*HALF_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              lj_mode,
  input  logic              clk_swap,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              tx_pin_a,
  output logic              tx_pin_b,
  output logic              tx_sd
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [SLOT_W-1:0] slot_idx;
  logic              bit_clk;
  logic              word_clk;
  logic              frame_end;
  logic [WORD_W-1:0] held_word;
  frame_mode_e       mode_q;
  logic              swap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  i2s_tx_timing #(.HALF_BITS(HALF_BITS), .HALF_TICKS(HALF_TICKS)) i_timing (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick_en   (tick_en),
    .slot_idx  (slot_idx),
    .bit_clk   (bit_clk),
    .frame_end (frame_end)
  );

  i2s_tx_frame_store #(.WORD_W(WORD_W)) i_store (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load      (frame_end),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .lj_in     (lj_mode),
    .swap_in   (clk_swap),
    .held_word (held_word),
    .mode_q    (mode_q),
    .swap_q    (swap_q)
  );

  i2s_tx_pins #(.HALF_BITS(HALF_BITS)) i_pins (
    .slot_idx  (slot_idx),
    .bit_clk   (bit_clk),
    .held_word (held_word),
    .mode      (mode_q),
    .swap      (swap_q),
    .word_clk  (word_clk),
    .pin_a     (tx_pin_a),
    .pin_b     (tx_pin_b),
    .sd        (tx_sd)
  );

  assign in_ready = frame_end;
endmodule

// File: rtl/i2s_stereo_tx_chk.sv
module i2s_stereo_tx_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              in_valid,
  input logic [WORD_W-1:0] in_data,
  input logic              in_ready,
  input logic              bit_clk,
  input logic [WORD_W-1:0] held_word,
  input logic              mode_q,
  input logic              swap_q,
  input logic              tx_pin_a,
  input logic              tx_pin_b,
  input logic              tx_sd
);
  // R7
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);

  // R2
  fetch_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> bit_clk);

  // R7
  accept_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid) |=> (held_word == $past(in_data)));

  // R8
  underrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> $stable(held_word));

  // R9
  mode_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> ($stable(mode_q) && $stable(swap_q)));

  // R10
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |-> !in_ready);

  // R10
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable({tx_pin_a, tx_pin_b, tx_sd}));
endmodule

bind i2s_stereo_tx i2s_stereo_tx_chk #(.WORD_W(WORD_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .in_ready  (in_ready),
  .bit_clk   (bit_clk),
  .held_word (held_word),
  .mode_q    (mode_q),
  .swap_q    (swap_q),
  .tx_pin_a  (tx_pin_a),
  .tx_pin_b  (tx_pin_b),
  .tx_sd     (tx_sd)
);

// File: tb/test_i2s_stereo_tx.sv
`timescale 1ns/1ps
module test_i2s_stereo_tx;
  logic        clk;
  logic        rst_n;
  logic        tick_en;
  logic        lj_mode;
  logic        clk_swap;
  logic        in_valid;
  logic [31:0] in_data;
  logic        in_ready;
  logic        tx_pin_a;
  logic        tx_pin_b;
  logic        tx_sd;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  i2s_stereo_tx i_i2s_stereo_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .lj_mode  (lj_mode),
    .clk_swap (clk_swap),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .tx_pin_a (tx_pin_a),
    .tx_pin_b (tx_pin_b),
    .tx_sd    (tx_sd)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected {pin_a, pin_b, sd} for tick state s (0..191) of a frame.
  function automatic logic [2:0] exp_pins(int s, logic [31:0] w, bit lj, bit sw);
    int  k  = s / 6;
    int  p  = s % 6;
    bit  bc = (p >= 3);
    bit  ws = lj ? (k < 16) : ((k < 15) || (k == 31));
    bit  d  = w[31-k];
    return sw ? {ws, bc, d} : {bc, ws, d};
  endfunction

  // Entered at a negedge where in_ready is high; leaves at the next such negedge.
  task automatic run_frame(string req, bit give, logic [31:0] data, logic [31:0] expw,
                           bit lj, bit sw, bit chg_mid, bit mid_lj, bit mid_sw,
                           bit stall);
    int  bad_pins = 0;
    int  bad_rdy  = 0;
    int  bad_stall = 0;
    int  first_s = -1;
    logic [2:0] first_act = '0;
    logic [2:0] first_exp = '0;
    in_valid = give;
    in_data  = data;
    lj_mode  = lj;
    clk_swap = sw;
    for (int s = 0; s < 192; s++) begin
      logic [2:0] e;
      logic [2:0] a;
      @(negedge clk);
      if (s == 0) begin
        in_valid = 1'b0;
        in_data  = 32'hDEAD_BEEF;
      end
      e = exp_pins(s, expw, lj, sw);
      a = {tx_pin_a, tx_pin_b, tx_sd};
      if (a !== e) begin
        if (first_s < 0) begin first_s = s; first_act = a; first_exp = e; end
        bad_pins++;
      end
      if (in_ready !== (s == 191)) bad_rdy++;
      if (chg_mid && s == 60) begin
        lj_mode  = mid_lj;
        clk_swap = mid_sw;
      end
      if (stall && s == 100) begin
        tick_en = 1'b0;
        repeat (8) begin
          @(negedge clk);
          if ({tx_pin_a, tx_pin_b, tx_sd} !== e || in_ready !== 1'b0) bad_stall++;
        end
        tick_en = 1'b1;
      end
    end
    if (first_s >= 0)
      $display("  first mismatch at tick %0d: pins %b vs %b", first_s, first_act, first_exp);
    check(bad_pins == 0, req, "pin waveform mismatches", bad_pins, 0);
    check(bad_rdy == 0, "R7", "ready timing mismatches", bad_rdy, 0);
    if (stall) check(bad_stall == 0, "R10", "stall mismatches", bad_stall, 0);
  endtask

  task automatic test_reset();
    check({tx_pin_a, tx_pin_b, tx_sd} === 3'b110, "R1", "reset pins",
          int'({tx_pin_a, tx_pin_b, tx_sd}), 3'b110);
    check(in_ready === 1'b0, "R1", "reset ready", int'(in_ready), 0);
    repeat (4) @(negedge clk);
    check({tx_pin_a, tx_pin_b, tx_sd, in_ready} === 4'b1100, "R1", "idle before tick",
          int'({tx_pin_a, tx_pin_b, tx_sd, in_ready}), 4'b1100);
  endtask

  task automatic wait_first_fetch();
    int n = 0;
    tick_en = 1'b1;
    @(negedge clk);
    while (in_ready !== 1'b1 && n < 400) begin
      @(negedge clk);
      n++;
    end
    // reset state is the first high tick of slot 31: two more ticks to the fetch
    check(n == 1, "R7", "ticks to first fetch", n + 1, 2);
  endtask

  initial begin
    rst_n    = 1'b0;
    tick_en  = 1'b0;
    lj_mode  = 1'b0;
    clk_swap = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    test_reset();
    wait_first_fetch();
    // R8: underrun straight after reset sends silence
    run_frame("R8", 1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R3 / R4: standard framing, new word
    run_frame("R3", 1'b1, 32'hA5C3_1E96, 32'hA5C3_1E96, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R8: repeat on underrun
    run_frame("R8", 1'b0, 32'h1234_5678, 32'hA5C3_1E96, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R4: standard framing, alternating pattern
    run_frame("R4", 1'b1, 32'h8001_7FFE, 32'h8001_7FFE, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R5: left-justified
    run_frame("R5", 1'b1, 32'h0F0F_F0F0, 32'h0F0F_F0F0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R6: swapped pins, standard and left-justified
    run_frame("R6", 1'b1, 32'hC0DE_3A5B, 32'hC0DE_3A5B, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    run_frame("R6", 1'b0, 32'h0, 32'hC0DE_3A5B, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    // R9: mid-frame change has no effect until the boundary
    run_frame("R9", 1'b1, 32'h5555_AAAA, 32'h5555_AAAA, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    run_frame("R9", 1'b0, 32'h0, 32'h5555_AAAA, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    // R10 / R2: stalled ticks mid-frame
    run_frame("R2", 1'b1, 32'hFFFF_0001, 32'hFFFF_0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule